// File: doc/BRIEF.md
# Paged Address Translator with Associative Translation Buffer

The block turns a logical address from the processor into a physical address. The upper bits of the logical address form a page number and the lower bits form an in-page offset. A small fully associative buffer holds recent page-to-frame pairs and is searched in one cycle. On a hit the frame number and the unchanged offset form the physical address, and no memory access is made. On a miss the block reads one page-table entry from main memory, at the table base plus the page number. A valid entry answers the request and is copied into the buffer. A clear valid bit answers with an invalid-page fault.

A page number that is not below the table length input is refused at once with a length fault, and no memory is read. Only one translation is handled at a time. While a table read is outstanding, ready is held low. A flush input empties the buffer in one cycle and is meant for use when the table base changes. The page size is set by the offset-width parameter, which covers 512 to 8192 bytes (9 to 13 bits).

Top module: `paged_xlat`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_rd_en is 0, and the buffer is empty, so the first legal request misses.
- R2: On a successful translation, rsp_paddr is the frame number in its upper FRAME_W bits and the request's low OFF_W offset bits unchanged. On any fault, rsp_paddr is 0.
- R3: A legal request that misses the buffer produces a one-cycle mem_rd_en pulse in the cycle after acceptance, with mem_rd_addr equal to ptbr plus the page number (req_laddr bits above OFF_W).
- R4: A legal request whose page is held in the buffer is answered with rsp_valid and rsp_fault = 00 in the cycle after acceptance, with no memory read.
- R5: A request whose page number is greater than or equal to ptlr is answered in the cycle after acceptance with rsp_fault = 01 and no memory read. This holds even when the page is held in the buffer.
- R6: A fetched entry whose valid bit (mem_rd_data bit FRAME_W) is 0 is answered, in the cycle after mem_rd_valid, with rsp_fault = 10. Nothing is installed, so the same page misses again.
- R7: A fetched valid entry (frame in mem_rd_data bits FRAME_W-1:0) is answered in the cycle after mem_rd_valid. It is installed in the slot under a round-robin pointer that starts at slot 0 and advances on each install, so ENTRIES further distinct fills evict it.
- R8: req_ready is low from the cycle after a missing request is accepted until the cycle after mem_rd_valid. At most one translation is in progress.
- R9: While flush is high, every lookup misses. At the end of that cycle every buffer entry is cleared, and a fill that completes in a flush cycle is answered but not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | PN_W+OFF_W | Logical address: page number above the offset |
| ptbr | input | MA_W | Page-table base address in memory |
| ptlr | input | PN_W+1 | Page-table length; legal pages are below it |
| flush | input | 1 | Clear all buffer entries |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 none, 01 length fault, 10 invalid-page fault |
| mem_rd_en | output | 1 | One-cycle table read request |
| mem_rd_addr | output | MA_W | Table entry address |
| mem_rd_valid | input | 1 | Table read data present |
| mem_rd_data | input | FRAME_W+1 | Entry: valid bit on top, frame number below |

## Verification
The first request after reset and repeat requests to one page separate the miss path from the hit path. Varying the offset shows that it passes through unchanged. Page numbers at the length limit and just below it locate the boundary of the length check, and shrinking the length under a page in the buffer shows that the check has priority over a hit. Invalid table entries, fills that pass the buffer size, and flushes held over a lookup and over a fill arrival test round-robin eviction and the clearing rules. A long back-to-back stream with mixed memory latency exercises the ready stall.

// File: rtl/paged_xlat_pkg.sv
package paged_xlat_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_LEN  = 2'b01,
        FLT_INV  = 2'b10
    } fault_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } walk_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/paged_xlat_cam.sv
module paged_xlat_cam
    import paged_xlat_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int PN_W    = 8,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [PN_W-1:0]    look_pn,
    input  logic               ins_en,
    input  logic [PN_W-1:0]    ins_pn,
    input  logic [FRAME_W-1:0] ins_frame,
    output logic               hit,
    output logic [FRAME_W-1:0] hit_frame,
    output logic [ENTRIES-1:0] hit_vec
);

    localparam int IDX_W = idx_width(ENTRIES);

    typedef struct packed {
        logic               vld;
        logic [PN_W-1:0]    pn;
        logic [FRAME_W-1:0] frame;
    } slot_t;

    logic [IDX_W-1:0]   victim;
    logic [FRAME_W-1:0] masked [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            victim <= '0;
        end else if (ins_en && !flush) begin
            victim <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        slot_t slot;

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slot.vld <= 1'b0;
            end else if (ins_en && victim == IDX_W'(i)) begin
                slot <= '{vld: 1'b1, pn: ins_pn, frame: ins_frame};
            end
        end

        assign hit_vec[i] = slot.vld && !flush && (slot.pn == look_pn);
        assign masked[i]  = hit_vec[i] ? slot.frame : '0;
    end

    always_comb begin
        hit_frame = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            hit_frame = hit_frame | masked[k];
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/paged_xlat_ctrl.sv
module paged_xlat_ctrl
    import paged_xlat_pkg::*;
#(
    parameter int PN_W    = 8,
    parameter int OFF_W   = 10,
    parameter int FRAME_W = 8,
    parameter int MA_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [PN_W+OFF_W-1:0]    req_laddr,
    input  logic [MA_W-1:0]          ptbr,
    input  logic [PN_W:0]            ptlr,
    output logic [PN_W-1:0]          look_pn,
    input  logic                     hit,
    input  logic [FRAME_W-1:0]       hit_frame,
    output logic                     rsp_valid,
    output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
    output logic [1:0]               rsp_fault,
    output logic                     mem_rd_en,
    output logic [MA_W-1:0]          mem_rd_addr,
    input  logic                     mem_rd_valid,
    input  logic [FRAME_W:0]         mem_rd_data,
    output logic                     ins_en,
    output logic [PN_W-1:0]          ins_pn,
    output logic [FRAME_W-1:0]       ins_frame
);

    walk_e             state;
    logic [PN_W-1:0]   held_pn;
    logic [OFF_W-1:0]  held_off;
    logic [OFF_W-1:0]  look_off;
    logic              out_of_range;
    logic              pte_ok;

    assign look_pn      = req_laddr[OFF_W +: PN_W];
    assign look_off     = req_laddr[OFF_W-1:0];
    assign out_of_range = {1'b0, look_pn} >= ptlr;
    assign req_ready    = (state == ST_IDLE);
    assign pte_ok       = mem_rd_data[FRAME_W];

    assign ins_en    = (state == ST_WAIT) && mem_rd_valid && pte_ok;
    assign ins_pn    = held_pn;
    assign ins_frame = mem_rd_data[FRAME_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            rsp_valid   <= 1'b0;
            rsp_fault   <= FLT_NONE;
            rsp_paddr   <= '0;
            mem_rd_en   <= 1'b0;
            mem_rd_addr <= '0;
            held_pn     <= '0;
            held_off    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            mem_rd_en <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        held_pn  <= look_pn;
                        held_off <= look_off;
                        if (out_of_range) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= FLT_LEN;
                            rsp_paddr <= '0;
                        end else if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= FLT_NONE;
                            rsp_paddr <= {hit_frame, look_off};
                        end else begin
                            mem_rd_en   <= 1'b1;
                            mem_rd_addr <= ptbr + MA_W'(look_pn);
                            state       <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                        if (pte_ok) begin
                            rsp_fault <= FLT_NONE;
                            rsp_paddr <= {mem_rd_data[FRAME_W-1:0], held_off};
                        end else begin
                            rsp_fault <= FLT_INV;
                            rsp_paddr <= '0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/paged_xlat.sv
module paged_xlat
    import paged_xlat_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int PN_W    = 8,
    parameter int OFF_W   = 10,
    parameter int FRAME_W = 8,
    parameter int MA_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [PN_W+OFF_W-1:0]    req_laddr,
    input  logic [MA_W-1:0]          ptbr,
    input  logic [PN_W:0]            ptlr,
    input  logic                     flush,
    output logic                     rsp_valid,
    output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
    output logic [1:0]               rsp_fault,
    output logic                     mem_rd_en,
    output logic [MA_W-1:0]          mem_rd_addr,
    input  logic                     mem_rd_valid,
    input  logic [FRAME_W:0]         mem_rd_data
);

    logic [PN_W-1:0]    look_pn;
    logic               cam_hit;
    logic [FRAME_W-1:0] cam_frame;
    logic [ENTRIES-1:0] cam_hit_vec;
    logic               ins_en;
    logic [PN_W-1:0]    ins_pn;
    logic [FRAME_W-1:0] ins_frame;

    paged_xlat_cam #(
        .ENTRIES(ENTRIES),
        .PN_W   (PN_W),
        .FRAME_W(FRAME_W)
    ) u_cam (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .look_pn  (look_pn),
        .ins_en   (ins_en),
        .ins_pn   (ins_pn),
        .ins_frame(ins_frame),
        .hit      (cam_hit),
        .hit_frame(cam_frame),
        .hit_vec  (cam_hit_vec)
    );

    paged_xlat_ctrl #(
        .PN_W   (PN_W),
        .OFF_W  (OFF_W),
        .FRAME_W(FRAME_W),
        .MA_W   (MA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_laddr   (req_laddr),
        .ptbr        (ptbr),
        .ptlr        (ptlr),
        .look_pn     (look_pn),
        .hit         (cam_hit),
        .hit_frame   (cam_frame),
        .rsp_valid   (rsp_valid),
        .rsp_paddr   (rsp_paddr),
        .rsp_fault   (rsp_fault),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid(mem_rd_valid),
        .mem_rd_data (mem_rd_data),
        .ins_en      (ins_en),
        .ins_pn      (ins_pn),
        .ins_frame   (ins_frame)
    );

endmodule

// File: rtl/paged_xlat_chk.sv
module paged_xlat_chk #(
    parameter int ENTRIES = 4,
    parameter int PN_W    = 8,
    parameter int OFF_W   = 10,
    parameter int FRAME_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [PN_W+OFF_W-1:0]    req_laddr,
    input logic [PN_W:0]            ptlr,
    input logic                     rsp_valid,
    input logic [FRAME_W+OFF_W-1:0] rsp_paddr,
    input logic [1:0]               rsp_fault,
    input logic                     mem_rd_en,
    input logic                     mem_rd_valid,
    input logic                     pte_valid_bit,
    input logic [ENTRIES-1:0]       hit_vec
);

    logic accept;
    assign accept = req_valid && req_ready;

    p_read_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    p_stall_on_read_r8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !req_ready);

    p_answer_or_read_r4: assert property (@(posedge clk) disable iff (rst)
        accept |=> (rsp_valid != mem_rd_en));

    p_single_hit_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_length_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && ({1'b0, req_laddr[PN_W+OFF_W-1:OFF_W]} >= ptlr))
        |=> (rsp_valid && rsp_fault == 2'b01 && !mem_rd_en));

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!rsp_valid || rsp_fault != 2'b00 ||
                    rsp_paddr[OFF_W-1:0] == $past(req_laddr[OFF_W-1:0])));

    p_fault_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

    p_invalid_fault_r6: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && mem_rd_valid && !pte_valid_bit)
        |=> (rsp_valid && rsp_fault == 2'b10));

endmodule

bind paged_xlat paged_xlat_chk #(
    .ENTRIES(ENTRIES),
    .PN_W   (PN_W),
    .OFF_W  (OFF_W),
    .FRAME_W(FRAME_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_laddr    (req_laddr),
    .ptlr         (ptlr),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_valid (mem_rd_valid),
    .pte_valid_bit(mem_rd_data[FRAME_W]),
    .hit_vec      (cam_hit_vec)
);

// File: tb/paged_xlat_bench.sv
module paged_xlat_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 4;
    localparam int PN_W    = 8;
    localparam int OFF_W   = 10;
    localparam int FRAME_W = 8;
    localparam int MA_W    = 16;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     req_valid = 1'b0;
    logic                     req_ready;
    logic [PN_W+OFF_W-1:0]    req_laddr = '0;
    logic [MA_W-1:0]          ptbr = 16'h0100;
    logic [PN_W:0]            ptlr = 9'd200;
    logic                     flush = 1'b0;
    logic                     rsp_valid;
    logic [FRAME_W+OFF_W-1:0] rsp_paddr;
    logic [1:0]               rsp_fault;
    logic                     mem_rd_en;
    logic [MA_W-1:0]          mem_rd_addr;
    logic                     mem_rd_valid = 1'b0;
    logic [FRAME_W:0]         mem_rd_data = '0;

    paged_xlat #(
        .ENTRIES(ENTRIES), .PN_W(PN_W), .OFF_W(OFF_W),
        .FRAME_W(FRAME_W), .MA_W(MA_W)
    ) u_paged_xlat (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .ptbr(ptbr), .ptlr(ptlr), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    int    lat      = 1;
    bit    done     = 0;

    // Page table contents: valid unless address low 3 bits are 5, frame = addr[7:0] ^ 0x5A
    function automatic logic [FRAME_W:0] pte_of(input logic [MA_W-1:0] a);
        return {(a[2:0] != 3'd5), a[7:0] ^ 8'h5A};
    endfunction

    // Behavioural reference model
    bit                    m_armed = 0;
    bit                    m_vld [ENTRIES];
    int                    m_pn  [ENTRIES];
    int                    m_fr  [ENTRIES];
    int                    m_ptr;
    bit                    m_busy;
    int                    m_off_h;
    bit                    e_rsp_valid, e_mem_en, e_ready;
    logic [1:0]            e_fault;
    logic [FRAME_W+OFF_W-1:0] e_paddr;
    logic [MA_W-1:0]       e_addr;

    always @(posedge clk) begin
        if (rst) begin
            m_armed = 1;
            for (int i = 0; i < ENTRIES; i++) m_vld[i] = 0;
            m_ptr = 0; m_busy = 0;
            e_rsp_valid = 0; e_mem_en = 0; e_ready = 1;
        end else begin
            e_rsp_valid = 0;
            e_mem_en    = 0;
            if (m_busy) begin
                if (mem_rd_valid) begin
                    e_rsp_valid = 1;
                    m_busy = 0;
                    if (mem_rd_data[FRAME_W]) begin
                        e_fault = 2'b00;
                        e_paddr = {mem_rd_data[FRAME_W-1:0], OFF_W'(m_off_h)};
                        if (!flush) begin
                            m_vld[m_ptr] = 1;
                            m_pn[m_ptr]  = int'(e_addr - ptbr);
                            m_fr[m_ptr]  = int'(mem_rd_data[FRAME_W-1:0]);
                            m_ptr = (m_ptr + 1) % ENTRIES;
                        end
                    end else begin
                        e_fault = 2'b10;
                        e_paddr = '0;
                    end
                end
            end else if (req_valid) begin
                int pn;
                int off;
                int found;
                pn  = int'(req_laddr >> OFF_W);
                off = int'(req_laddr[OFF_W-1:0]);
                found = -1;
                for (int i = 0; i < ENTRIES; i++)
                    if (m_vld[i] && m_pn[i] == pn && !flush) found = i;
                if (pn >= int'(ptlr)) begin
                    e_rsp_valid = 1; e_fault = 2'b01; e_paddr = '0;
                end else if (found >= 0) begin
                    e_rsp_valid = 1; e_fault = 2'b00;
                    e_paddr = {FRAME_W'(m_fr[found]), OFF_W'(off)};
                end else begin
                    e_mem_en = 1;
                    e_addr   = ptbr + MA_W'(pn);
                    m_off_h  = off;
                    m_busy   = 1;
                end
            end
            if (flush) for (int i = 0; i < ENTRIES; i++) m_vld[i] = 0;
            e_ready = !m_busy;
        end
    end

    task automatic check1(input string tag, input string what,
                          input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare against the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (m_armed && !rst && !done) begin
            check1("R8", "req_ready", req_ready, e_ready);
            check1(cur_req, "rsp_valid", rsp_valid, e_rsp_valid);
            check1("R3", "mem_rd_en", mem_rd_en, e_mem_en);
            if (e_mem_en) check1("R3", "mem_rd_addr", mem_rd_addr, e_addr);
            if (e_rsp_valid && rsp_valid) begin
                check1(cur_req, "rsp_fault", rsp_fault, e_fault);
                check1("R2", "rsp_paddr", rsp_paddr, e_paddr);
            end
        end
    end

    // Memory model with variable latency
    int            mem_cnt = 0;
    logic [MA_W-1:0] mem_a;
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (mem_cnt > 0) begin
            mem_cnt--;
            if (mem_cnt == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = pte_of(mem_a);
            end
        end
        if (!rst && mem_rd_en) begin
            mem_a   = mem_rd_addr;
            mem_cnt = lat;
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            done = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", wd, 100000);
            report();
        end
    end

    // Issue one request; returns at the negedge after acceptance
    task automatic do_req(input int pn, input int off);
        bit rdy;
        req_valid = 1'b1;
        req_laddr = {PN_W'(pn), OFF_W'(off)};
        forever begin
            rdy = req_ready;
            @(negedge clk);
            if (rdy) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check1("R1", "reset req_ready", req_ready, 1);
        check1("R1", "reset rsp_valid", rsp_valid, 0);
        check1("R1", "reset mem_rd_en", mem_rd_en, 0);
        @(negedge clk);

        cur_req = "R1"; lat = 2;
        do_req(3, 16'h155); idle(2);           // first request misses
        cur_req = "R4";
        do_req(3, 16'h2AA); idle(1);           // hit
        do_req(3, 16'h000); do_req(3, 16'h3FF); idle(1); // back-to-back hits, offset edges

        cur_req = "R6"; lat = 1;
        do_req(5, 16'h011); idle(1);           // invalid entry
        do_req(5, 16'h012); idle(1);           // misses again

        cur_req = "R5";
        do_req(200, 16'h001); idle(1);         // at limit
        do_req(255, 16'h001); idle(1);
        cur_req = "R3";
        do_req(199, 16'h0AB); idle(1);         // just below limit
        cur_req = "R5";
        ptlr = 9'd3;
        do_req(3, 16'h001); idle(1);           // held page, now out of range
        ptlr = 9'd200;

        cur_req = "R7"; lat = 3;
        do_req(10, 1); do_req(11, 2); do_req(12, 3); do_req(14, 4); idle(1);
        do_req(3, 5); idle(1);                 // evicted: miss
        do_req(11, 6); do_req(12, 7); idle(1); // still held

        cur_req = "R9";
        flush = 1'b1;
        do_req(14, 8);                         // lookup during flush misses
        flush = 1'b0;
        idle(1);
        do_req(20, 9);
        flush = 1'b1;                          // held over the fill arrival
        while (!req_ready) @(negedge clk);
        flush = 1'b0;
        @(negedge clk);
        do_req(20, 10); idle(1);               // not installed: miss
        do_req(12, 11); idle(1);               // cleared: miss

        cur_req = "R8";
        for (int k = 0; k < 60; k++) begin
            lat = 1 + (k % 3);
            do_req((k * 37 + 5) % 210, (k * 29) % 1024);
        end
        idle(2);

        done = 1;
        report();
    end

endmodule